// File: doc/BRIEF.md
# Banked 24-Bit Address Extender

This block sits between a processor with a 16-bit address bus and a 16 MB physical memory system. It produces a 24-bit physical address and a ROM select signal. It holds four 8-bit bank registers, a mode bit and a 2-bit data-bank selector. The processor writes these through a small window of control addresses.

Out of reset the block runs in boot mode. The upper byte of every physical address is forced to all ones, so the processor sees one 64 KB page. The ROM at the top of that page is the same ROM that sits at the top of the full 16 MB space. Firmware loads the bank registers and then sets the mode bit.

In full mode the upper byte depends on the cycle type:
- Opcode and operand fetches, flagged by the fetch input, take it from bank register 0. This lets code run anywhere in 16 MB.
- Data accesses take it from the bank register picked by the data-bank selector.

Top module: `addr_extender`

## Requirements
- R1: While reset is asserted, and after it is released, the block is in boot mode. All bank registers and the data-bank selector are zero.
- R2: In boot mode the physical address is 0xFF followed by the 16 processor address bits, for every cycle type.
- R3: In boot mode the ROM select is high exactly when processor address bits 15:14 are both one.
- R4: A write to control offset 0..3 (processor address 0xBF00 plus offset) loads the data byte into that bank register. The new value applies from the next cycle.
- R5: A write to control offset 4 (0xBF04) loads bit 0 as the mode (1 = full) and bits 2:1 as the data-bank selector. The new value applies from the next cycle.
- R6: In full mode a cycle with the fetch input high uses bank register 0 as the upper address byte.
- R7: In full mode a cycle with the fetch input low uses the bank register whose index equals the data-bank selector.
- R8: In full mode the ROM select is high exactly when physical address bits 23:14 are all one.
- R9: Reads, writes to control offsets 5..7, and writes outside the control window leave every register unchanged.
- R10: Writing 0 to bit 0 at offset 4 returns the block to boot mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | Processor address |
| code_fetch | input | 1 | High on opcode or operand fetch cycles |
| wr_en | input | 1 | High on processor write cycles |
| wr_data | input | 8 | Processor write data |
| phys_addr | output | 24 | Extended physical address |
| rom_sel | output | 1 | Physical address falls in the top ROM region |

## Verification
The assertions assume that:
- the processor inputs are stable across each rising edge;
- a write cycle is a single-cycle strobe whose address and data are valid together.

The bench meets this by changing inputs only on the falling edge and holding each access for one full cycle. Random stimulus aims half of its writes at the eight-address control window, so mode changes, selector changes and ignored offsets all occur mixed with ordinary fetches and data accesses.

// File: rtl/addrx_pkg.sv
package addrx_pkg;
    localparam int CPU_AW    = 16;
    localparam int PHYS_AW   = 24;
    localparam int NUM_BANKS = 4;

    typedef enum logic {
        MODE_BOOT = 1'b0,
        MODE_FULL = 1'b1
    } map_mode_e;
endpackage

// File: rtl/addrx_decode.sv
module addrx_decode #(
    parameter int          CPU_AW    = 16,
    parameter int          NUM_BANKS = 4,
    parameter int          WIN_AW    = 3,
    parameter logic [15:0] CTRL_BASE = 16'hBF00
) (
    input  logic [CPU_AW-1:0]    cpu_addr,
    input  logic                 wr_en,
    output logic [NUM_BANKS-1:0] bank_we,
    output logic                 ctl_we
);
    logic              in_win;
    logic [WIN_AW-1:0] win_off;

    assign in_win  = (cpu_addr[CPU_AW-1:WIN_AW] == CTRL_BASE[CPU_AW-1:WIN_AW]);
    assign win_off = cpu_addr[WIN_AW-1:0];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank_we
        assign bank_we[g] = wr_en && in_win && (win_off == WIN_AW'(g));
    end

    assign ctl_we = wr_en && in_win && (win_off == WIN_AW'(NUM_BANKS));
endmodule

// File: rtl/addrx_regs.sv
module addrx_regs
    import addrx_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int BANK_W    = 8,
    localparam int SEL_W    = $clog2(NUM_BANKS)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_BANKS-1:0]              bank_we,
    input  logic                              ctl_we,
    input  logic [BANK_W-1:0]                 wr_data,
    output logic [NUM_BANKS-1:0][BANK_W-1:0]  banks,
    output map_mode_e                         mode,
    output logic [SEL_W-1:0]                  dsel
);
    typedef struct packed {
        logic [NUM_BANKS-1:0][BANK_W-1:0] banks;
        map_mode_e                        mode;
        logic [SEL_W-1:0]                 dsel;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (bank_we[i]) st_d.banks[i] = wr_data;
        end
        if (ctl_we) begin
            st_d.mode = wr_data[0] ? MODE_FULL : MODE_BOOT;
            st_d.dsel = wr_data[SEL_W:1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{banks: '0, mode: MODE_BOOT, dsel: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign banks = st_q.banks;
    assign mode  = st_q.mode;
    assign dsel  = st_q.dsel;
endmodule

// File: rtl/addrx_map.sv
module addrx_map
    import addrx_pkg::*;
#(
    parameter int CPU_AW    = 16,
    parameter int PHYS_AW   = 24,
    parameter int NUM_BANKS = 4,
    parameter int ROM_AW    = 14,
    localparam int BANK_W   = PHYS_AW - CPU_AW,
    localparam int SEL_W    = $clog2(NUM_BANKS)
) (
    input  map_mode_e                        mode,
    input  logic                             code_fetch,
    input  logic [SEL_W-1:0]                 dsel,
    input  logic [NUM_BANKS-1:0][BANK_W-1:0] banks,
    input  logic [CPU_AW-1:0]                cpu_addr,
    output logic [PHYS_AW-1:0]               phys_addr,
    output logic                             rom_sel
);
    logic [BANK_W-1:0] upper;

    always_comb begin
        if (mode == MODE_BOOT) begin
            upper = '1;
        end else if (code_fetch) begin
            upper = banks[0];
        end else begin
            upper = banks[dsel];
        end
    end

    assign phys_addr = {upper, cpu_addr};
    assign rom_sel   = &phys_addr[PHYS_AW-1:ROM_AW];
endmodule

// File: rtl/addr_extender.sv
module addr_extender
    import addrx_pkg::*;
#(
    parameter logic [15:0] CTRL_BASE = 16'hBF00,
    parameter int          ROM_AW    = 14,
    localparam int         BANK_W    = PHYS_AW - CPU_AW,
    localparam int         SEL_W     = $clog2(NUM_BANKS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic               code_fetch,
    input  logic               wr_en,
    input  logic [BANK_W-1:0]  wr_data,
    output logic [PHYS_AW-1:0] phys_addr,
    output logic               rom_sel
);
    logic [NUM_BANKS-1:0]             bank_we;
    logic                             ctl_we;
    logic [NUM_BANKS-1:0][BANK_W-1:0] banks;
    map_mode_e                        mode;
    logic [SEL_W-1:0]                 dsel;
    logic                             full_mode;
    logic [BANK_W-1:0]                code_bank;

    addrx_decode #(
        .CPU_AW(CPU_AW), .NUM_BANKS(NUM_BANKS), .WIN_AW(3), .CTRL_BASE(CTRL_BASE)
    ) u_decode (
        .cpu_addr(cpu_addr), .wr_en(wr_en), .bank_we(bank_we), .ctl_we(ctl_we)
    );

    addrx_regs #(
        .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bank_we(bank_we), .ctl_we(ctl_we),
        .wr_data(wr_data), .banks(banks), .mode(mode), .dsel(dsel)
    );

    addrx_map #(
        .CPU_AW(CPU_AW), .PHYS_AW(PHYS_AW), .NUM_BANKS(NUM_BANKS), .ROM_AW(ROM_AW)
    ) u_map (
        .mode(mode), .code_fetch(code_fetch), .dsel(dsel), .banks(banks),
        .cpu_addr(cpu_addr), .phys_addr(phys_addr), .rom_sel(rom_sel)
    );

    assign full_mode = (mode == MODE_FULL);
    assign code_bank = banks[0];
endmodule

// File: rtl/addr_extender_chk.sv
module addr_extender_chk #(
    parameter logic [15:0] CTRL_BASE = 16'hBF00
) (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic        code_fetch,
    input logic        wr_en,
    input logic [7:0]  wr_data,
    input logic [23:0] phys_addr,
    input logic        rom_sel,
    input logic        full_mode,
    input logic [7:0]  code_bank,
    input logic [1:0]  dsel
);
    localparam logic [15:0] CTL_ADDR = 16'(CTRL_BASE + 16'd4);

    // R2
    boot_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !full_mode |-> phys_addr == {8'hFF, cpu_addr});

    // R3
    boot_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_mode && cpu_addr[15:14] == 2'b11) |-> rom_sel);

    // R4
    code_bank_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cpu_addr == CTRL_BASE) |=> code_bank == $past(wr_data));

    // R5
    mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cpu_addr == CTL_ADDR) |=> (full_mode == $past(wr_data[0]))
                                            && (dsel == $past(wr_data[2:1])));

    // R6
    code_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full_mode && code_fetch) |-> phys_addr[23:16] == code_bank);

    // R9
    read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(code_bank) && $stable(full_mode) && $stable(dsel));
endmodule

bind addr_extender addr_extender_chk #(.CTRL_BASE(CTRL_BASE)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .code_fetch(code_fetch),
    .wr_en(wr_en), .wr_data(wr_data), .phys_addr(phys_addr), .rom_sel(rom_sel),
    .full_mode(full_mode), .code_bank(code_bank), .dsel(dsel)
);

// File: tb/addr_extender_test.sv
module addr_extender_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] BASE = 16'hBF00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        code_fetch = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [23:0] phys_addr;
    logic        rom_sel;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] m_bank [4];
    logic       m_full;
    logic [1:0] m_sel;

    addr_extender uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .code_fetch(code_fetch),
        .wr_en(wr_en), .wr_data(wr_data), .phys_addr(phys_addr), .rom_sel(rom_sel)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [23:0] exp_phys(logic [15:0] a, logic f);
        if (!m_full) return {8'hFF, a};
        if (f) return {m_bank[0], a};
        return {m_bank[m_sel], a};
    endfunction

    task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%06h expected=%06h", req, act, exp);
        end
    endtask

    task automatic model_write(logic [15:0] a, logic [7:0] d);
        if (a[15:3] == BASE[15:3]) begin
            if (a[2:0] < 3'd4) m_bank[a[1:0]] = d;
            else if (a[2:0] == 3'd4) begin
                m_full = d[0];
                m_sel  = d[2:1];
            end
        end
    endtask

    // tag "" picks the tag from the model state
    task automatic step(logic [15:0] a, logic f, logic w, logic [7:0] d, string tag);
        logic [23:0] e;
        string ta, tr;
        @(negedge clk);
        cpu_addr = a; code_fetch = f; wr_en = w; wr_data = d;
        #1;
        e  = exp_phys(a, f);
        ta = (tag != "") ? tag : (!m_full ? "R2" : (f ? "R6" : "R7"));
        tr = (tag != "") ? tag : (!m_full ? "R3" : "R8");
        chk(ta, phys_addr, e);
        chk(tr, {23'd0, rom_sel}, {23'd0, &e[23:14]});
        if (w) model_write(a, d);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) m_bank[i] = 8'h00;
        m_full = 1'b0;
        m_sel  = 2'd0;
        void'($urandom(32'd1234));

        // R1: reset state seen at the outputs
        cpu_addr = 16'h4321;
        repeat (3) @(negedge clk);
        #1;
        chk("R1", phys_addr, 24'hFF4321);
        chk("R1", {23'd0, rom_sel}, 24'd0);
        @(negedge clk);
        rst_n = 1'b1;
        step(16'h0000, 1'b1, 1'b0, 8'h00, "R1");
        step(16'hC000, 1'b0, 1'b0, 8'h00, "");
        step(16'hBFFF, 1'b0, 1'b0, 8'h00, "");

        // R4: load all banks while still in boot mode
        step(BASE + 16'd0, 1'b0, 1'b1, 8'h12, "R4");
        step(BASE + 16'd1, 1'b0, 1'b1, 8'h34, "R4");
        step(BASE + 16'd2, 1'b0, 1'b1, 8'h56, "R4");
        step(BASE + 16'd3, 1'b0, 1'b1, 8'hFE, "R4");
        // R5: selector 2, full mode
        step(BASE + 16'd4, 1'b0, 1'b1, 8'b0000_0101, "R5");
        step(16'h4000, 1'b0, 1'b0, 8'h00, "R7");
        step(16'h0200, 1'b1, 1'b0, 8'h00, "R6");

        // R9: ignored offsets, reads and writes outside the window
        step(BASE + 16'd5, 1'b0, 1'b1, 8'hFF, "R9");
        step(BASE + 16'd7, 1'b0, 1'b1, 8'h00, "R9");
        step(BASE + 16'd0, 1'b0, 1'b0, 8'hAA, "R9");
        step(16'h3F00, 1'b0, 1'b1, 8'h99, "R9");
        step(16'h1000, 1'b1, 1'b0, 8'h00, "R9");
        step(16'h1000, 1'b0, 1'b0, 8'h00, "R9");

        // R8: ROM boundary in full mode
        step(BASE + 16'd0, 1'b0, 1'b1, 8'hFF, "R4");
        step(16'hC123, 1'b1, 1'b0, 8'h00, "R8");
        step(16'hBFFF, 1'b1, 1'b0, 8'h00, "R8");
        step(BASE + 16'd4, 1'b0, 1'b1, 8'b0000_0111, "R5");
        step(16'hFFFF, 1'b0, 1'b0, 8'h00, "R8");
        step(BASE + 16'd4, 1'b0, 1'b1, 8'b0000_0011, "R5");
        step(16'h5555, 1'b0, 1'b0, 8'h00, "R5");

        // random mix
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] a;
            logic w;
            a = 16'($urandom);
            w = ($urandom % 4) == 0;
            if (w && ($urandom % 2) == 0) a = {BASE[15:3], 3'($urandom)};
            step(a, 1'($urandom), w, 8'($urandom), "");
        end

        // R10: back to boot mode
        step(BASE + 16'd4, 1'b0, 1'b1, 8'h00, "R10");
        step(16'h8000, 1'b1, 1'b0, 8'h00, "R10");
        step(16'hF000, 1'b0, 1'b0, 8'h00, "R10");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule